// File: doc/BRIEF.md
# Dual-Output Shared-Counter PWM Generator

This block is the pulse-width modulation mode of a small timer. One free-running period counter advances on each qualified tick and wraps from its all-ones value back to zero, so one PWM period is 2^CNT_W ticks. Two channels compare the shared count against their own active duty value. Each channel drives an output that is high from count zero and drops when the count reaches the duty value.

Software may write a new duty value into either channel at any time. The write only lands in a shadow register. The shadow is copied into the active compare register when the counter wraps, so a change always starts at a period boundary and no pulse is ever cut short or stretched. Each channel has its own polarity input that inverts its output. When the interrupt enable is set, a one-cycle interrupt pulse marks the start of every period.

While the block runs, the counter serves only the PWM function. The period is always the full count range, whatever the duty values are, and there is no clear-on-match.

Top module: `dpwm_core`

## Requirements
- R1: After reset the count is 0, both active and shadow duty values are 0, the interrupt output is low, and each output equals its polarity input (a duty of 0 gives a low level, which is then inverted by polarity).
- R2: The count rises by exactly one on each clock where `tick` is high, and holds when `tick` is low.
- R3: On a tick at count 2^CNT_W-1 the count goes to 0. The period is always 2^CNT_W ticks, whatever the duty values are (no clear on a duty match).
- R4: With polarity 0, an output is high while count < active duty and low from count == active duty up to the end of the period. A duty of 0 keeps the output low for the whole period.
- R5: An active duty of 2^CNT_W-1 (255 by default) keeps the output high for the whole period, including at the top count.
- R6: A duty write changes only the shadow. The output keeps following the old active duty until the counter next wraps.
- R7: On the wrap tick, each channel's shadow is copied to its active duty. A write that falls in the same cycle as the wrap tick goes straight to the new active duty and applies from count 0.
- R8: A polarity input of 1 inverts that channel's output. The effect is combinational, in the same cycle.
- R9: `period_irq` is high for exactly the one cycle after a wrap tick, and only if `irq_en` was high during the wrap cycle. Otherwise it stays low.
- R10: The two channels are independent. A write, duty or polarity on one channel never changes the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance qualifier (prescaled tick) |
| duty_a_wr | input | 1 | Write strobe for channel A duty shadow |
| duty_a_data | input | CNT_W | New duty value for channel A |
| duty_b_wr | input | 1 | Write strobe for channel B duty shadow |
| duty_b_data | input | CNT_W | New duty value for channel B |
| pol_a | input | 1 | Channel A output inversion |
| pol_b | input | 1 | Channel B output inversion |
| irq_en | input | 1 | Enables the per-period interrupt pulse |
| count | output | CNT_W | Current value of the shared period counter |
| pwm_a | output | 1 | Channel A PWM output |
| pwm_b | output | 1 | Channel B PWM output |
| period_irq | output | 1 | One-cycle pulse at the start of each period |

## Verification
Two functions can coincide in one cycle: a software duty write and the wrap tick that reloads the active duty from the shadow. The bench provokes this on purpose. In directed steps, and with raised probability during random runs, it drives a write exactly when its model shows the count at the top value with `tick` high. It then checks that the written value, not the older shadow contents, sets the output from count 0 of the new period. The same cycle also raises the interrupt, so the bench checks the pulse next to the reloaded duty.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int unsigned DPWM_CH = 2;

  // Output level before polarity: high below the duty, forced high at full scale
  function automatic logic pwm_level(input logic [31:0] cnt,
                                     input logic [31:0] duty,
                                     input logic [31:0] full);
    return (duty == full) || (cnt < duty);
  endfunction

  // True on the tick that closes a period
  function automatic logic at_wrap(input logic        adv,
                                   input logic [31:0] cnt,
                                   input logic [31:0] full);
    return adv && (cnt == full);
  endfunction

endpackage

// File: rtl/dpwm_period_ctr.sv
module dpwm_period_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  import dpwm_pkg::*;

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap_evt = at_wrap(tick, 32'(cnt_q), 32'(FULL));
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= wrap_evt ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap_evt,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             pol,
  output logic [CNT_W-1:0] active,
  output logic             out
);
  import dpwm_pkg::*;

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;
  logic             level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr) begin
      shadow_q <= wdata;
    end
  end

  // A write on the wrap cycle bypasses the shadow into the new period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (wrap_evt) begin
      active_q <= wr ? wdata : shadow_q;
    end
  end

  assign level  = pwm_level(32'(cnt), 32'(active_q), 32'(FULL));
  assign out    = level ^ pol;
  assign active = active_q;

endmodule

// File: rtl/dpwm_irq.sv
module dpwm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic irq_en,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= wrap_evt && irq_en;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/dpwm_core.sv
module dpwm_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             duty_a_wr,
  input  logic [CNT_W-1:0] duty_a_data,
  input  logic             duty_b_wr,
  input  logic [CNT_W-1:0] duty_b_data,
  input  logic             pol_a,
  input  logic             pol_b,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             period_irq
);
  import dpwm_pkg::*;

  logic                         wrap_evt;
  logic [CNT_W-1:0]             cnt;
  logic [DPWM_CH-1:0]           ch_wr;
  logic [DPWM_CH-1:0]           ch_pol;
  logic [DPWM_CH-1:0]           ch_out;
  logic [DPWM_CH-1:0][CNT_W-1:0] ch_data;
  logic [DPWM_CH-1:0][CNT_W-1:0] ch_active;
  logic [CNT_W-1:0]             active_a;
  logic [CNT_W-1:0]             active_b;

  assign ch_wr   = {duty_b_wr, duty_a_wr};
  assign ch_pol  = {pol_b, pol_a};
  assign ch_data = {duty_b_data, duty_a_data};

  dpwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt      (cnt),
    .wrap_evt (wrap_evt)
  );

  for (genvar g = 0; g < DPWM_CH; g++) begin : g_ch
    dpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .wrap_evt (wrap_evt),
      .wr       (ch_wr[g]),
      .wdata    (ch_data[g]),
      .pol      (ch_pol[g]),
      .active   (ch_active[g]),
      .out      (ch_out[g])
    );
  end

  dpwm_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_evt (wrap_evt),
    .irq_en   (irq_en),
    .irq      (period_irq)
  );

  assign active_a = ch_active[0];
  assign active_b = ch_active[1];
  assign count    = cnt;
  assign pwm_a    = ch_out[0];
  assign pwm_b    = ch_out[1];

endmodule

// File: rtl/dpwm_core_chk.sv
module dpwm_core_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             irq_en,
  input logic             pol_a,
  input logic             duty_a_wr,
  input logic [CNT_W-1:0] duty_a_data,
  input logic [CNT_W-1:0] count,
  input logic             wrap_evt,
  input logic [CNT_W-1:0] active_a,
  input logic [CNT_W-1:0] active_b,
  input logic             pwm_a,
  input logic             period_irq
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R3
  count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == FULL) |=> (count == '0));

  // R6
  active_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(active_a));

  // R6
  active_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(active_b));

  // R7
  bypass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && duty_a_wr) |=> (active_a == $past(duty_a_data)));

  // R5
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_a == FULL) |-> (pwm_a == !pol_a));

  // R9
  irq_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |-> (count == '0));

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !period_irq);

endmodule

bind dpwm_core dpwm_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .irq_en      (irq_en),
  .pol_a       (pol_a),
  .duty_a_wr   (duty_a_wr),
  .duty_a_data (duty_a_data),
  .count       (count),
  .wrap_evt    (wrap_evt),
  .active_a    (active_a),
  .active_b    (active_b),
  .pwm_a       (pwm_a),
  .period_irq  (period_irq)
);

// File: tb/tb_dpwm_core.sv
`timescale 1ns/1ps
module tb_dpwm_core;

  localparam int W = 8;
  localparam logic [W-1:0] TOPV = 8'hFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         a_wr = 1'b0, b_wr = 1'b0;
  logic [W-1:0] a_dat = '0, b_dat = '0;
  logic         pa = 1'b0, pb = 1'b0, ien = 1'b0;
  logic [W-1:0] count;
  logic         pwm_a, pwm_b, period_irq;

  int unsigned  n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  // bench model state
  logic [W-1:0] m_cnt = '0, m_sha = '0, m_shb = '0, m_aca = '0, m_acb = '0;
  logic         m_irq = 1'b0;

  always #2.5 clk = ~clk;

  dpwm_core #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .duty_a_wr(a_wr), .duty_a_data(a_dat),
    .duty_b_wr(b_wr), .duty_b_data(b_dat),
    .pol_a(pa), .pol_b(pb), .irq_en(ien),
    .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .period_irq(period_irq)
  );

  function automatic logic exp_out(logic [W-1:0] c, logic [W-1:0] d, logic p);
    logic hi;
    if (d == TOPV) hi = 1'b1;
    else           hi = (c < d);
    return hi ^ p;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (count %0d)", tag, act, exp, m_cnt);
    end
  endtask

  // At a negedge: drive, check, advance model across the next posedge
  task automatic step(input logic t, input logic wa, input logic [W-1:0] da,
                      input logic wb, input logic [W-1:0] db);
    logic         wrap;
    logic [W-1:0] n_cnt, n_sha, n_shb, n_aca, n_acb;
    tick = t; a_wr = wa; a_dat = da; b_wr = wb; b_dat = db;
    #0.5;
    chk("R2 count", int'(count), int'(m_cnt));
    chk(m_aca == TOPV ? "R5 pwm_a" : (pa ? "R8 pwm_a" : "R4 pwm_a"),
        int'(pwm_a), int'(exp_out(m_cnt, m_aca, pa)));
    chk("R10 pwm_b", int'(pwm_b), int'(exp_out(m_cnt, m_acb, pb)));
    chk("R9 irq", int'(period_irq), int'(m_irq));
    wrap  = t && (m_cnt == TOPV);
    n_cnt = t ? (wrap ? '0 : m_cnt + 1'b1) : m_cnt;
    n_sha = wa ? da : m_sha;
    n_shb = wb ? db : m_shb;
    n_aca = wrap ? n_sha : m_aca;
    n_acb = wrap ? n_shb : m_acb;
    @(posedge clk);
    m_irq = wrap && ien;
    m_cnt = n_cnt; m_sha = n_sha; m_shb = n_shb; m_aca = n_aca; m_acb = n_acb;
    @(negedge clk);
  endtask

  task automatic run_to(input logic [W-1:0] target);
    while (m_cnt != target) step(1'b1, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 pwm_a", int'(pwm_a), 0);
    chk("R1 pwm_b", int'(pwm_b), 0);
    chk("R1 irq", int'(period_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pa = 1'b1; pb = 1'b1;
    #0.5;
    chk("R1 R8 pwm_a pol", int'(pwm_a), 1);
    chk("R1 R8 pwm_b pol", int'(pwm_b), 1);
    pa = 1'b0; pb = 1'b0;

    // R6: write into shadow without ticks, output keeps old duty
    step(1'b0, 1'b1, 8'd100, 1'b1, 8'd200);
    step(1'b0, 1'b0, '0, 1'b0, '0);
    chk("R6 pwm_a stays low", int'(pwm_a), 0);
    chk("R6 pwm_b stays low", int'(pwm_b), 0);
    ien = 1'b1;
    run_to(8'd0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    run_to(TOPV);
    step(1'b1, 1'b0, '0, 1'b0, '0);   // wrap tick, shadow loads
    #0.5;
    chk("R7 pwm_a after load", int'(pwm_a), 1);
    chk("R9 irq pulse", int'(period_irq), 1);
    chk("R3 count at 0", int'(count), 0);

    // R5 full scale and duty 0, with polarity mix
    step(1'b1, 1'b1, TOPV, 1'b1, 8'd0);
    run_to(TOPV);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    run_to(TOPV);
    #0.5;
    chk("R5 pwm_a high at top", int'(pwm_a), 1);
    chk("R4 pwm_b low duty 0", int'(pwm_b), 0);

    // R7: write on the wrap cycle bypasses to the new period
    step(1'b1, 1'b1, 8'd3, 1'b0, '0);
    #0.5;
    chk("R7 bypass count", int'(count), 0);
    chk("R7 bypass pwm_a", int'(pwm_a), 1);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    #0.5;
    chk("R7 R4 pwm_a falls at duty", int'(pwm_a), 0);
    chk("R10 pwm_b unaffected", int'(pwm_b), 0);
    ien = 1'b0;
    run_to(TOPV);
    step(1'b1, 1'b0, '0, 1'b0, '0);
    #0.5;
    chk("R9 irq masked", int'(period_irq), 0);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      logic t, wa, wb;
      t = ($urandom % 4) != 0;
      if (m_cnt == TOPV && t) begin
        wa = ($urandom % 2) == 0; wb = ($urandom % 2) == 0;
      end else begin
        wa = ($urandom % 40) == 0; wb = ($urandom % 40) == 0;
      end
      if (($urandom % 300) == 0) pa = ~pa;
      if (($urandom % 300) == 0) pb = ~pb;
      if (($urandom % 500) == 0) ien = ~ien;
      step(t, wa, 8'($urandom), wb, 8'($urandom));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule